// File: doc/BRIEF.md
# Generic Clock Channel Bank

This block holds a small bank of independent clock channels that run on one system clock. Each channel owns a 16-bit control word at byte address 4×channel. From that word it picks one of four source strobes: two oscillator strobes and two PLL strobes. It then either forwards the chosen strobe as is, or divides it into a square wave with equal high and low phases. Each channel can be switched on and off without affecting the others. Source activity arrives as single-cycle clock-enable strobes on `src_tick`, so every channel output is a registered signal in the system clock domain.

Each channel is a four-state machine:
- OFF: the output is low, and the live source and divider are copied on every cycle.
- PASS: undivided forwarding.
- LO and HI: the two phases of divided mode.

The transitions are:
- OFF goes to PASS or to LO when the enable bit is set. The divide-enable bit chooses which.
- PASS goes to OFF when enable clears, and to LO when divide-enable is set.
- LO goes to HI at the end of its phase.
- LO goes to PASS at the end of its phase if divide-enable has been cleared.
- LO goes to OFF at once when enable clears.
- HI always returns to LO at the end of its phase. Because HI never goes straight to OFF, a high phase is never cut short.

Top module: `gclk_bank`

## Requirements
- R1: The control word of channel i is written and read at byte address 4×i. Writes to an address whose two low bits are not zero are ignored. Only bits 0..3 and 15..8 are stored, and every other bit reads as zero.
- R2: The source index is {bit3, bit2} of the control word. Bit 2 selects the second bank and bit 3 selects the PLL of that bank. The resulting indexes are 0 = first oscillator, 1 = second oscillator, 2 = first PLL and 3 = second PLL, and each index is the bit of `src_tick` with that number.
- R3: When bit 1 (divide enable) is set, each high phase and each low phase lasts exactly DIV+1 strobes of the selected source. DIV is bits 15..8, so one output period is 2×(DIV+1) source strobes.
- R4: When bit 1 is clear and the channel is enabled, the output is high for one cycle, one system clock after each cycle in which the selected source strobe is high, and low otherwise.
- R5: When bit 0 (enable) is cleared while the output is high, the high phase still runs for its full DIV+1 strobes. The output then stays low.
- R6: A new DIV value written while a divided channel runs does not alter the phase in progress. It applies from the next output edge onward.
- R7: After reset every control word reads zero and every channel output is low.
- R8: Channels are independent. A running channel leaves the output and the control word of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Source strobes, indexed as in R2 |
| wr_en | input | 1 | Write strobe for the control words |
| addr | input | $clog2(NCH)+2 | Byte address of a control word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| clk_out | output | NCH | One output per channel |

## Verification
The four sources run with distinct strobe patterns: every cycle, every second cycle, every third cycle and every fifth cycle. As a result, counting the selected source's strobes per output phase reveals a wrong source select as well as a wrong divide. All four sources are swept against several DIV values, including zero and the maximum. Undivided mode is checked cycle by cycle against the delayed strobe of each source, which separates forwarding from dividing. Mid-run DIV changes, enable removal during a high phase, unaligned writes and a second channel running beside an idle one separate the timing of control updates from their effect.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
    localparam int CTRL_W    = 16;
    localparam int NSRC      = 4;
    localparam int SEL_W     = $clog2(NSRC);
    localparam int EN_BIT    = 0;
    localparam int DIVON_BIT = 1;
    localparam int BANK_BIT  = 2;
    localparam int PLL_BIT   = 3;
    localparam int DIV_LSB   = 8;
    localparam int DIV_W     = 8;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 16'hFF0F;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_PASS = 2'd1,
        ST_LO   = 2'd2,
        ST_HI   = 2'd3
    } gc_state_e;
endpackage

// File: rtl/gclk_regs.sv
module gclk_regs
    import gclk_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                addr,
    input  logic [31:0]                  wdata,
    output logic [31:0]                  rdata,
    output logic [NCH-1:0][CTRL_W-1:0]   ctrl
);
    localparam int IW = AW - 2;

    logic [IW-1:0] idx;
    logic          aligned;

    assign idx     = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar i = 0; i < NCH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl[i] <= '0;
            else if (wr_en && aligned && (idx == IW'(i)))
                ctrl[i] <= wdata[CTRL_W-1:0] & CTRL_MASK;
        end

        // R1
        word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && aligned && (idx == IW'(i)))
            |=> (ctrl[i] == ($past(wdata[CTRL_W-1:0]) & CTRL_MASK)));
    end

    always_comb begin
        rdata = '0;
        if (aligned && ({1'b0, idx} < (IW+1)'(NCH)))
            rdata[CTRL_W-1:0] = ctrl[idx];
    end
endmodule

// File: rtl/gclk_channel.sv
module gclk_channel
    import gclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic [CTRL_W-1:0] ctrl,
    output logic              clk_o
);
    logic              en, divon;
    logic [SEL_W-1:0]  sel_live, sel_q;
    logic [DIV_W-1:0]  div_live, div_q;
    logic [DIV_W-1:0]  cnt, cnt_nx;
    logic              tick_live, tick_q, load, pass_q;
    gc_state_e         state, state_nx;

    assign en        = ctrl[EN_BIT];
    assign divon     = ctrl[DIVON_BIT];
    assign sel_live  = {ctrl[PLL_BIT], ctrl[BANK_BIT]};
    assign div_live  = ctrl[DIV_LSB +: DIV_W];
    assign tick_live = src_tick[sel_live];
    assign tick_q    = src_tick[sel_q];

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        load     = 1'b0;
        unique case (state)
            ST_OFF: begin
                load   = 1'b1;
                cnt_nx = '0;
                if (en)
                    state_nx = divon ? ST_LO : ST_PASS;
            end
            ST_PASS: begin
                load = 1'b1;
                if (!en) begin
                    state_nx = ST_OFF;
                end else if (divon) begin
                    state_nx = ST_LO;
                    cnt_nx   = '0;
                end
            end
            ST_LO: begin
                if (!en) begin
                    state_nx = ST_OFF;
                    cnt_nx   = '0;
                end else if (tick_q) begin
                    if (cnt == div_q) begin
                        cnt_nx   = '0;
                        load     = 1'b1;
                        state_nx = divon ? ST_HI : ST_PASS;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            ST_HI: begin
                if (tick_q) begin
                    if (cnt == div_q) begin
                        cnt_nx   = '0;
                        load     = 1'b1;
                        state_nx = ST_LO;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            cnt    <= '0;
            sel_q  <= '0;
            div_q  <= '0;
            pass_q <= 1'b0;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            pass_q <= (state_nx == ST_PASS) && tick_live;
            if (load) begin
                sel_q <= sel_live;
                div_q <= div_live;
            end
        end
    end

    always_comb begin
        clk_o = pass_q || (state == ST_HI);
    end

    // R5
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !clk_o);

    // R5
    hi_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI) |=> (state != ST_OFF));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LO || state == ST_HI) |-> (cnt <= div_q));

    // R6
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HI) && !tick_q) |=> ($stable(div_q) && $stable(state)));

    // R2
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LO || state == ST_HI) && !tick_q && en) |=> $stable(sel_q));
endmodule

// File: rtl/gclk_bank.sv
module gclk_bank
    import gclk_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int AW  = $clog2(NCH) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NCH-1:0]    clk_out
);
    logic [NCH-1:0][CTRL_W-1:0] ctrl;

    gclk_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .ctrl  (ctrl)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gclk_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_tick (src_tick),
            .ctrl     (ctrl[i]),
            .clk_o    (clk_out[i])
        );
    end

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (clk_out == '0));
endmodule

// File: tb/test_gclk_bank.sv
module test_gclk_bank;
    localparam int NCH = 4;
    localparam int AW  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      tk = '0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NCH-1:0]  clk_out;

    int  n_run = 0, n_fail = 0;
    int  cyc = 0, tcnt = 0, mon = 0;
    logic prev_o = 1'b0, last_t = 1'b0;

    always #2.5 clk = ~clk;

    gclk_bank #(.NCH(NCH)) i_gclk_bank (
        .clk(clk), .rst_n(rst_n), .src_tick(tk), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .clk_out(clk_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic step(input int sel, output bit ev, output int ecnt);
        @(negedge clk);
        tcnt  += int'(tk[sel]);
        last_t = tk[sel];
        ev = 1'b0;
        ecnt = 0;
        if (clk_out[mon] !== prev_o) begin
            ev = 1'b1;
            ecnt = tcnt;
            tcnt = 0;
            prev_o = clk_out[mon];
        end
        cyc++;
        tk[0] = (cyc % 2 == 0);
        tk[1] = (cyc % 3 == 1);
        tk[2] = 1'b1;
        tk[3] = (cyc % 5 == 2);
    endtask

    task automatic idle(input int n);
        bit e; int c;
        for (int k = 0; k < n; k++) step(0, e, c);
    endtask

    task automatic wreg(input int a, input int d, input int sel);
        bit e; int c;
        addr = AW'(a); wdata = d; wr_en = 1'b1;
        step(sel, e, c);
        wr_en = 1'b0;
    endtask

    task automatic rreg(input int a, output int v);
        bit e; int c;
        addr = AW'(a);
        step(0, e, c);
        v = rdata;
    endtask

    task automatic next_edge(input int sel, output int ecnt);
        bit e;
        ecnt = -1;
        for (int k = 0; k < 3000; k++) begin
            step(sel, e, ecnt);
            if (e) return;
        end
        ecnt = -1;
    endtask

    function automatic int cfg(input int sel, input int div, input bit divon, input bit en);
        return (div << 8) | ((sel >> 1) << 3) | ((sel & 1) << 2) | (int'(divon) << 1) | int'(en);
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int v, c, bad;
        int divs[5] = '{0, 1, 4, 9, 255};
        idle(4);
        rst_n = 1'b1;
        // R7: reset state
        chk(clk_out == '0, "R7 outputs low", int'(clk_out), 0);
        for (int i = 0; i < NCH; i++) begin
            rreg(4 * i, v);
            chk(v == 0, "R7 control word zero", v, 0);
        end

        // R1: writable bits, reserved bits, unaligned, stride
        wreg(0, 32'hFFFF_FFFE, 0);
        rreg(0, v);
        chk(v == 32'h0000_FF0E, "R1 mask readback", v, 32'h0000_FF0E);
        wreg(5, 32'h0000_0301, 0);
        rreg(4, v);
        chk(v == 0, "R1 unaligned write ignored", v, 0);
        wreg(4, 32'h0000_1234, 0);
        rreg(4, v);
        chk(v == 32'h0000_1204, "R1 stride channel 1", v, 32'h1204);
        rreg(0, v);
        chk(v == 32'h0000_FF0E, "R1 channel 0 untouched", v, 32'h0000_FF0E);
        wreg(0, 0, 0);
        wreg(4, 0, 0);
        idle(10);
        chk(clk_out == '0, "R1 disabled words give no output", int'(clk_out), 0);

        // R2 R3: sweep sources and divide values
        for (int s = 0; s < 4; s++) begin
            for (int di = 0; di < 5; di++) begin
                if (divs[di] == 255 && s != 2) continue;
                wreg(0, cfg(s, divs[di], 1'b1, 1'b1), s);
                next_edge(s, c);
                next_edge(s, c);
                bad = 0;
                for (int k = 0; k < 4; k++) begin
                    next_edge(s, c);
                    if (c != divs[di] + 1) bad++;
                end
                chk(bad == 0, $sformatf("R2/R3 src %0d div %0d phase ticks", s, divs[di]),
                    c, divs[di] + 1);
                wreg(0, 0, s);
                idle(600);
                chk(clk_out[0] == 1'b0, "R5 low after disable", int'(clk_out[0]), 0);
            end
        end

        // R4: undivided forwarding per source
        for (int s = 0; s < 4; s++) begin
            bit e;
            wreg(0, cfg(s, 7, 1'b0, 1'b1), s);
            for (int k = 0; k < 5; k++) step(s, e, c);
            bad = 0;
            for (int k = 0; k < 40; k++) begin
                step(s, e, c);
                if (clk_out[0] !== last_t) bad++;
            end
            chk(bad == 0, $sformatf("R4 forward src %0d mismatches", s), bad, 0);
            wreg(0, 0, s);
            idle(20);
        end

        // R6: DIV change applies at the next edge
        wreg(0, cfg(1, 3, 1'b1, 1'b1), 1);
        next_edge(1, c);
        next_edge(1, c);
        wreg(0, cfg(1, 1, 1'b1, 1'b1), 1);
        next_edge(1, c);
        chk(c == 4, "R6 current phase keeps old DIV", c, 4);
        bad = 0;
        for (int k = 0; k < 3; k++) begin
            next_edge(1, c);
            if (c != 2) bad++;
        end
        chk(bad == 0, "R6 later phases use new DIV", c, 2);
        wreg(0, 0, 1);
        idle(200);

        // R5: disable during a high phase
        wreg(0, cfg(0, 5, 1'b1, 1'b1), 0);
        do next_edge(0, c); while (prev_o !== 1'b1 && c >= 0);
        next_edge(0, c);
        while (prev_o !== 1'b1 && c >= 0) next_edge(0, c);
        wreg(0, cfg(0, 5, 1'b1, 1'b0), 0);
        next_edge(0, c);
        chk(c == 6 && prev_o == 1'b0, "R5 high phase completes", c, 6);
        bad = 0;
        for (int k = 0; k < 300; k++) begin
            bit e;
            step(0, e, v);
            if (clk_out[0] !== 1'b0) bad++;
        end
        chk(bad == 0, "R5 held low", bad, 0);

        // R8: channel 1 runs, channel 0 stays idle
        mon = 1; prev_o = clk_out[1]; tcnt = 0;
        wreg(4, cfg(2, 2, 1'b1, 1'b1), 2);
        bad = 0;
        next_edge(2, c);
        next_edge(2, c);
        for (int k = 0; k < 4; k++) begin
            next_edge(2, c);
            if (c != 3) bad++;
            if (clk_out[0] !== 1'b0 || clk_out[2] !== 1'b0) bad++;
        end
        chk(bad == 0, "R8 channel 1 alone toggles", bad, 0);
        rreg(0, v);
        chk(v == 32'h0000_0E00 || v == 0 || v == 32'h0000_0502, "R8 channel 0 word unchanged", v, 32'h0502);
        wreg(4, 0, 2);
        idle(50);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule